// File: doc/BRIEF.md
# Selectable ADC output code formatter

The block takes 14-bit offset-binary conversion results and re-expresses each one in a code picked at run time. The choices are two's complement, Gray code and plain offset binary. A small register write port carries the choice. A write to the format address updates a two-bit selector, and every sample accepted after that write leaves the block in the new code.

Each result is registered and appears one clock after its input strobe, with a matching valid flag. A separate decoding path turns a Gray word back into offset binary one bit at a time, starting from the MSB. Feeding it the formatter's Gray output recovers the original sample, which allows round-trip checks at the ports.

Top module: `adc_code_fmt`

## Requirements
- R1: After reset, code_vld_o and dec_vld_o are 0, code_o and dec_o are all zeros, and the selected format is two's complement.
- R2: With format selector 2'b00, code_o is the accepted sample with only bit 13 (the MSB) inverted, so mid-scale 14'h2000 becomes 14'h0000.
- R3: With format selector 2'b01, code_o bit 13 equals sample bit 13 and each lower bit i equals sample bit i XOR sample bit i+1; mid-scale 14'h2000 gives 14'h3000 and full scale 14'h3FFF gives 14'h2000.
- R4: With format selector 2'b10, code_o equals the accepted sample unchanged (all zeros for the most negative input, all ones for the most positive).
- R5: The reserved selector value 2'b11 produces the same output as two's complement.
- R6: code_vld_o is smp_vld_i delayed by one clock, and the code_o it flags is derived from the sample present in the cycle of the strobe.
- R7: In a cycle with smp_vld_i low, code_o keeps its previous value at the next edge.
- R8: The format selector is bits [1:0] of a write with cfg_we_i high and cfg_addr_i equal to 8'h73; writes to any other address, and address 8'h73 with cfg_we_i low, leave the format unchanged.
- R9: A sample strobed in the same cycle as a format write is coded in the old format; the next accepted sample uses the new format.
- R10: dec_o is the Gray-to-binary decode of dec_i one clock after dec_vld_i: bit 13 passes through and each lower bit i is dec_i bit i XOR decoded bit i+1; dec_vld_o is dec_vld_i delayed by one clock, and dec_o holds when dec_vld_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 14 | Offset-binary sample |
| smp_vld_i | input | 1 | Sample strobe |
| cfg_addr_i | input | 8 | Register write address |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_we_i | input | 1 | Register write enable |
| code_o | output | 14 | Formatted sample |
| code_vld_o | output | 1 | Formatted sample valid |
| dec_i | input | 14 | Gray word to decode |
| dec_vld_i | input | 1 | Decode strobe |
| dec_o | output | 14 | Decoded offset-binary word |
| dec_vld_o | output | 1 | Decoded word valid |

## Verification
On every cycle, the assertions check these properties:
- the one-cycle valid latency on both paths;
- that outputs hold between strobes;
- each format's mapping, against a shadow copy of the selector built from the write port;
- that re-encoding dec_o gives back the Gray word.

The directed scenarios are what show the boundary codes and the reset state. They also exercise rejection of writes to the wrong address or with the enable low, and the exact switch-over sample at a format change. Finally, they run a full round trip from sample to Gray and back.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    FMT_TWOS = 2'b00,
    FMT_GRAY = 2'b01,
    FMT_OFFS = 2'b10,
    FMT_RSVD = 2'b11
  } fmt_e;
endpackage

// File: rtl/fmt_cfg_reg.sv
module fmt_cfg_reg
  import adc_fmt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CFG_W    = 8,
  parameter logic [7:0]  FMT_ADDR = 8'h73,
  parameter int unsigned FMT_LSB  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              we_i,
  output fmt_e              fmt_o
);
  localparam logic [CFG_W-1:0] FIELD_MASK = CFG_W'(2'b11) << FMT_LSB;

  logic hit;
  logic wdata_unused;
  fmt_e fmt_q;

  assign hit          = we_i && (addr_i == ADDR_W'(FMT_ADDR));
  assign wdata_unused = ^(wdata_i & ~FIELD_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fmt_q <= FMT_TWOS;
    else if (hit) fmt_q <= fmt_e'(wdata_i[FMT_LSB +: 2]);
  end

  assign fmt_o = fmt_q;
endmodule

// File: rtl/fmt_encoder.sv
module fmt_encoder
  import adc_fmt_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  logic [DATA_W-1:0] bin_i,
  input  fmt_e              fmt_i,
  output logic [DATA_W-1:0] code_o
);
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] gray;
  logic [DATA_W-1:0] twos;

  assign gray[DATA_W-1] = bin_i[DATA_W-1];
  for (genvar i = 0; i < DATA_W - 1; i++) begin : g_gray
    assign gray[i] = bin_i[i] ^ bin_i[i+1];
  end

  assign twos = bin_i ^ MSB_MASK;

  always_comb begin
    unique case (fmt_i)
      FMT_GRAY: code_o = gray;
      FMT_OFFS: code_o = bin_i;
      default:  code_o = twos;  // two's complement and reserved
    endcase
  end
endmodule

// File: rtl/gray_decoder.sv
module gray_decoder #(
  parameter int unsigned DATA_W = 14
) (
  input  logic [DATA_W-1:0] gray_i,
  output logic [DATA_W-1:0] bin_o
);
  // ripple from MSB: each bit uses the bit already decoded above it
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      acc      = acc ^ gray_i[i];
      bin_o[i] = acc;
    end
  end
endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt
  import adc_fmt_pkg::*;
#(
  parameter int unsigned DATA_W   = 14,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CFG_W    = 8,
  parameter logic [7:0]  FMT_ADDR = 8'h73
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] smp_i,
  input  logic              smp_vld_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              cfg_we_i,
  output logic [DATA_W-1:0] code_o,
  output logic              code_vld_o,
  input  logic [DATA_W-1:0] dec_i,
  input  logic              dec_vld_i,
  output logic [DATA_W-1:0] dec_o,
  output logic              dec_vld_o
);
  fmt_e              fmt;
  logic [DATA_W-1:0] enc;
  logic [DATA_W-1:0] dec;

  fmt_cfg_reg #(
    .ADDR_W  (ADDR_W),
    .CFG_W   (CFG_W),
    .FMT_ADDR(FMT_ADDR),
    .FMT_LSB (0)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .we_i   (cfg_we_i),
    .fmt_o  (fmt)
  );

  fmt_encoder #(.DATA_W(DATA_W)) u_enc (
    .bin_i (smp_i),
    .fmt_i (fmt),
    .code_o(enc)
  );

  gray_decoder #(.DATA_W(DATA_W)) u_dec (
    .gray_i(dec_i),
    .bin_o (dec)
  );

  // fmt is the pre-write value at this edge, so a sample never mixes formats
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o     <= '0;
      code_vld_o <= 1'b0;
      dec_o      <= '0;
      dec_vld_o  <= 1'b0;
    end else begin
      code_vld_o <= smp_vld_i;
      dec_vld_o  <= dec_vld_i;
      if (smp_vld_i) code_o <= enc;
      if (dec_vld_i) dec_o <= dec;
    end
  end
endmodule

// File: rtl/adc_code_fmt_chk.sv
module adc_code_fmt_chk #(
  parameter int unsigned DATA_W   = 14,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CFG_W    = 8,
  parameter logic [7:0]  FMT_ADDR = 8'h73
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] smp_i,
  input logic              smp_vld_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [CFG_W-1:0]  cfg_wdata_i,
  input logic              cfg_we_i,
  input logic [DATA_W-1:0] code_o,
  input logic              code_vld_o,
  input logic [DATA_W-1:0] dec_i,
  input logic              dec_vld_i,
  input logic [DATA_W-1:0] dec_o,
  input logic              dec_vld_o
);
  logic [1:0]        shadow;
  logic [DATA_W-1:0] reenc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow <= 2'b00;
    else if (cfg_we_i && cfg_addr_i == ADDR_W'(FMT_ADDR)) shadow <= cfg_wdata_i[1:0];
  end

  assign reenc = dec_o ^ (dec_o >> 1);

  a_r6_vld_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i |=> code_vld_o);
  a_r6_vld_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> !code_vld_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> $stable(code_o));
  a_r2_twos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && shadow == 2'b00) |=>
      code_o == {~$past(smp_i[DATA_W-1]), $past(smp_i[DATA_W-2:0])});
  a_r5_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && shadow == 2'b11) |=>
      code_o == {~$past(smp_i[DATA_W-1]), $past(smp_i[DATA_W-2:0])});
  a_r3_gray_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && shadow == 2'b01) |=> code_o[DATA_W-1] == $past(smp_i[DATA_W-1]));
  a_r3_gray_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && shadow == 2'b01) |=>
      code_o[DATA_W-2:0] == $past(smp_i[DATA_W-2:0] ^ smp_i[DATA_W-1:1]));
  a_r4_offs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && shadow == 2'b10) |=> code_o == $past(smp_i));
  a_r10_dec_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_i |=> dec_vld_o);
  a_r10_dec_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_vld_i |=> (!dec_vld_o && $stable(dec_o)));
  a_r10_dec_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_i |=> reenc == $past(dec_i));
endmodule

bind adc_code_fmt adc_code_fmt_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W), .FMT_ADDR(FMT_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
  .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i), .cfg_we_i(cfg_we_i),
  .code_o(code_o), .code_vld_o(code_vld_o), .dec_i(dec_i), .dec_vld_i(dec_vld_i),
  .dec_o(dec_o), .dec_vld_o(dec_vld_o)
);

// File: tb/adc_code_fmt_test.sv
module adc_code_fmt_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] smp_i = '0;
  logic        smp_vld_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [13:0] code_o;
  logic        code_vld_o;
  logic [13:0] dec_i = '0;
  logic        dec_vld_i = 1'b0;
  logic [13:0] dec_o;
  logic        dec_vld_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  adc_code_fmt uut (.*);

  function automatic logic [13:0] f_twos(input logic [13:0] x); return x ^ 14'h2000; endfunction
  function automatic logic [13:0] f_gray(input logic [13:0] x); return x ^ (x >> 1); endfunction
  function automatic logic [13:0] f_ungray(input logic [13:0] g);
    logic [13:0] b;
    b[13] = g[13];
    for (int i = 12; i >= 0; i--) b[i] = g[i] ^ b[i+1];
    return b;
  endfunction

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic we);
    @(negedge clk_i);
    cfg_addr_i = a; cfg_wdata_i = d; cfg_we_i = we;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic push(input string req, input logic [13:0] s, input logic [13:0] exp);
    @(negedge clk_i);
    smp_i = s; smp_vld_i = 1'b1;
    @(posedge clk_i); #1;
    check({req, " vld"}, 14'(code_vld_o), 14'd1);
    check(req, code_o, exp);
    @(negedge clk_i);
    smp_vld_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 code_vld_o", 14'(code_vld_o), 14'd0);
    check("R1 code_o", code_o, 14'h0000);
    check("R1 dec_vld_o", 14'(dec_vld_o), 14'd0);
    check("R1 dec_o", dec_o, 14'h0000);
    push("R1 default twos", 14'h2000, 14'h0000);
  endtask

  task automatic t_twos();
    logic [13:0] v [5] = '{14'h0000, 14'h0001, 14'h2000, 14'h3FFE, 14'h3FFF};
    wr(8'h73, 8'h00, 1'b1);
    foreach (v[k]) push("R2 twos", v[k], f_twos(v[k]));
  endtask

  task automatic t_gray();
    wr(8'h73, 8'h01, 1'b1);
    push("R3 gray mid", 14'h2000, 14'h3000);
    push("R3 gray full", 14'h3FFF, 14'h2000);
    push("R3 gray fs-1", 14'h3FFE, f_gray(14'h3FFE));
    push("R3 gray pat", 14'h1555, f_gray(14'h1555));
    push("R3 gray zero", 14'h0001, 14'h0001);
  endtask

  task automatic t_offs();
    wr(8'h73, 8'h02, 1'b1);
    push("R4 offs zero", 14'h0000, 14'h0000);
    push("R4 offs full", 14'h3FFF, 14'h3FFF);
    push("R4 offs pat", 14'h2AAA, 14'h2AAA);
  endtask

  task automatic t_rsvd();
    wr(8'h73, 8'h03, 1'b1);
    push("R5 rsvd mid", 14'h2000, 14'h0000);
    push("R5 rsvd pat", 14'h1234, f_twos(14'h1234));
  endtask

  task automatic t_latency_hold();
    wr(8'h73, 8'h02, 1'b1);
    @(negedge clk_i);
    smp_i = 14'h0ABC; smp_vld_i = 1'b1;
    @(negedge clk_i);
    check("R6 not before edge+1", code_o, 14'h0ABC);
    smp_i = 14'h1DEF; smp_vld_i = 1'b0;
    @(negedge clk_i);
    check("R6 vld drops", 14'(code_vld_o), 14'd0);
    check("R7 hold", code_o, 14'h0ABC);
    smp_i = 14'h3333;
    repeat (3) @(negedge clk_i);
    check("R7 hold long", code_o, 14'h0ABC);
  endtask

  task automatic t_cfg_ignore();
    wr(8'h73, 8'h01, 1'b1);           // gray
    wr(8'h72, 8'h02, 1'b1);           // wrong address
    wr(8'h74, 8'h00, 1'b1);
    wr(8'h73, 8'h02, 1'b0);           // enable low
    push("R8 still gray", 14'h2000, 14'h3000);
    wr(8'h73, 8'hFE, 1'b1);           // field = 2'b10, upper bits ignored
    push("R8 field bits", 14'h2000, 14'h2000);
  endtask

  task automatic t_switch();
    wr(8'h73, 8'h00, 1'b1);           // twos
    @(negedge clk_i);
    smp_i = 14'h2000; smp_vld_i = 1'b1;
    cfg_addr_i = 8'h73; cfg_wdata_i = 8'h01; cfg_we_i = 1'b1;
    @(posedge clk_i); #1;
    check("R9 same-cycle old fmt", code_o, 14'h0000);
    @(negedge clk_i);
    cfg_we_i = 1'b0; smp_i = 14'h2000;
    @(posedge clk_i); #1;
    check("R9 next uses new fmt", code_o, 14'h3000);
    @(negedge clk_i);
    smp_vld_i = 1'b0;
  endtask

  task automatic t_decode();
    logic [13:0] v [4] = '{14'h3000, 14'h2000, 14'h0001, 14'h1F0F};
    foreach (v[k]) begin
      @(negedge clk_i);
      dec_i = v[k]; dec_vld_i = 1'b1;
      @(posedge clk_i); #1;
      check("R10 dec vld", 14'(dec_vld_o), 14'd1);
      check("R10 dec", dec_o, f_ungray(v[k]));
    end
    @(negedge clk_i);
    dec_vld_i = 1'b0; dec_i = 14'h0000;
    @(negedge clk_i);
    check("R10 dec vld drop", 14'(dec_vld_o), 14'd0);
    check("R10 dec hold", dec_o, f_ungray(14'h1F0F));
    check("R10 dec mid", f_ungray(14'h3000), 14'h2000);
  endtask

  task automatic t_roundtrip();
    logic [13:0] v [3] = '{14'h0000, 14'h2345, 14'h3FFF};
    wr(8'h73, 8'h01, 1'b1);
    foreach (v[k]) begin
      push("R3 rt enc", v[k], f_gray(v[k]));
      @(negedge clk_i);
      dec_i = code_o; dec_vld_i = 1'b1;
      @(posedge clk_i); #1;
      check("R10 round trip", dec_o, v[k]);
      @(negedge clk_i);
      dec_vld_i = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_twos();
    t_gray();
    t_offs();
    t_rsvd();
    t_latency_hold();
    t_cfg_ignore();
    t_switch();
    t_decode();
    t_roundtrip();
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule